// File: doc/BRIEF.md
# Cartridge Banking and Per-Tile Attribute Controller

This block is the address-mapping core of a game cartridge. It watches the console CPU bus and the picture-processor (PPU) bus. From them it produces program ROM, work-RAM and character ROM addresses, and the selector that picks which half of the console's internal nametable RAM a fetch reaches. A 16-entry register window repeats across CPU $8000-$BFFF, and address bits 3:0 choose the entry. Entries for the sound channels and the interval timer are not stored here. They are decoded into one-cycle write strobes for neighbouring blocks.

The block also holds a write-only palette memory with one 2-bit value per nametable tile, for both physical nametables. When this feature is enabled, an attribute fetch by the PPU is answered from that memory instead of from the coarse 2x2-tile attribute byte. The answer uses the entry of the tile fetched just before it.

All interfaces are plain bus pins with no flow control. A CPU write is a single-cycle `cpu_wr` pulse and always completes, so there is no back-pressure on either bus. Address and strobe outputs are combinational from the bus inputs and the register state. Register state changes on the clock edge that samples `cpu_wr`.

Top module: `cart_map_core`

## Requirements
- R1: A CPU address in $8000-$BFFF drives `prg_rom_addr` = {bank, cpu_addr[13:0]}. The bank is the low 4 bits last written to window entry $B. `prg_rom_ce` is high for any address at or above $8000.
- R2: A CPU address in $C000-$FFFF drives `prg_rom_addr` = {4'hF, cpu_addr[13:0]}, whatever the bank register holds.
- R3: In $8000-$BFFF only address bits 3:0 pick the register entry. Writes at $C000-$FFFF, or to other entries, leave the bank register unchanged.
- R4: Entries $C, $D, $E and $F hold 4-bit character banks for PPU $0000, $0800, $1000 and $1800. For PPU addresses below $2000, `chr_addr` = {bank, ppu_addr[10:0]} and `chr_ce` is high.
- R5: Entry $A bits 1:0 choose the mirroring that drives `ciram_a10`: 0 gives ppu_addr[10], 1 gives ppu_addr[11], 2 gives constant 0 and 3 gives constant 1.
- R6: For CPU $6000-$7FFF, `prg_ram_ce` is high and `prg_ram_addr` = cpu_addr[12:0]. `prg_ram_we` follows `cpu_wr` only while entry $A bit 3 is set, and is held low otherwise.
- R7: A write pulse to entry k, for k from 0 to 9, raises `aux_wr[k]` during that same cycle, with all other bits low. Entries $A-$F, and writes outside $8000-$BFFF, raise no bit.
- R8: A CPU write in $C000-$FFFF stores wdata[1:0] at palette index cpu_addr[10:0]. This happens whether or not the feature is enabled.
- R9: A PPU read whose address has bit 13 set and bits 9:6 not equal to 4'hF is a tile fetch. On the next clock edge it latches the palette entry at index {ciram_a10, ppu_addr[9:0]}. While entry $A bit 2 is set, a PPU read with bit 13 set and bits 9:6 = 4'hF raises `attr_ovr` and drives `attr_data` = four copies of the latched entry.
- R10: While entry $A bit 2 is clear, `attr_ovr` is low and `attr_data` is zero.
- R11: After reset, the bank registers and entry $A are all zero. Mirroring is therefore vertical, work-RAM writes are blocked and the override is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | One-cycle CPU write pulse |
| ppu_addr | input | 14 | PPU address |
| ppu_rd | input | 1 | PPU read strobe |
| prg_rom_addr | output | 18 | Program ROM address |
| prg_rom_ce | output | 1 | Program ROM select |
| prg_ram_addr | output | 13 | Work RAM address |
| prg_ram_ce | output | 1 | Work RAM select |
| prg_ram_we | output | 1 | Gated work RAM write strobe |
| chr_addr | output | 15 | Character ROM address |
| chr_ce | output | 1 | Character ROM select |
| ciram_a10 | output | 1 | Nametable RAM half select |
| ciram_ce | output | 1 | Nametable RAM select |
| attr_ovr | output | 1 | Attribute override active |
| attr_data | output | 8 | Replacement attribute byte |
| aux_wr | output | 10 | Write strobes for entries 0-9 |

## Verification
The bench writes the bank entry through aliases such as $BFFB and $807B, and with upper data bits set. A decoder that looks at more than bits 3:0, or that keeps all data bits, would land on the wrong ROM bank. It writes $C00B and checks that the bank survives, which catches a decoder that responds to the upper half. It drives the same tile offset, $523, through vertical, horizontal and single-screen mirroring, so a wrong half select would return the other table's palette. It also toggles the RAM write enable and the override enable, and probes entries $9 and $A. A gate left open, or a strobe range off by one, would then show up as a stray strobe.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORIZ = 2'd1,
    MIR_ONE_A = 2'd2,
    MIR_ONE_B = 2'd3
  } mirror_e;

  typedef struct packed {
    logic    ram_wr_en;
    logic    xattr_en;
    mirror_e mirror;
  } ctrl_t;

  localparam logic [3:0] OFS_CTRL     = 4'hA;
  localparam logic [3:0] OFS_PRG      = 4'hB;
  localparam logic [3:0] OFS_CHR_BASE = 4'hC;

  localparam int PRG_WIN_W = 14;
  localparam int CHR_WIN_W = 11;
  localparam int RAM_AW    = 13;
  localparam int NT_OFS_W  = 10;
endpackage

// File: rtl/cmap_regs.sv
module cmap_regs
  import cmap_pkg::*;
#(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 4,
  parameter int AUX_N      = 10,
  localparam int CHR_SLOTS = 2 ** (13 - CHR_WIN_W)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cpu_wr,
  input  logic [15:0]                       cpu_addr,
  input  logic [7:0]                        cpu_wdata,
  output logic [PRG_BANK_W-1:0]             prg_bank,
  output logic [CHR_SLOTS*CHR_BANK_W-1:0]   chr_bank,
  output ctrl_t                             ctrl,
  output logic [AUX_N-1:0]                  aux_wr,
  output logic                              xattr_wr
);
  logic       win_hit;
  logic [3:0] ofs;
  logic       unused_regs;

  assign ofs         = cpu_addr[3:0];
  assign win_hit     = cpu_wr && (cpu_addr[15:14] == 2'b10);
  assign xattr_wr    = cpu_wr && (cpu_addr[15:14] == 2'b11);
  assign unused_regs = ^{cpu_addr[13:4], cpu_wdata[7:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_bank <= '0;
    end else if (win_hit && ofs == OFS_PRG) begin
      prg_bank <= cpu_wdata[PRG_BANK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (win_hit && ofs == OFS_CTRL) begin
      ctrl <= ctrl_t'(cpu_wdata[3:0]);
    end
  end

  for (genvar s = 0; s < CHR_SLOTS; s++) begin : g_chr
    localparam logic [3:0] SLOT_OFS = OFS_CHR_BASE + 4'(s);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chr_bank[s*CHR_BANK_W +: CHR_BANK_W] <= '0;
      end else if (win_hit && ofs == SLOT_OFS) begin
        chr_bank[s*CHR_BANK_W +: CHR_BANK_W] <= cpu_wdata[CHR_BANK_W-1:0];
      end
    end
  end

  for (genvar k = 0; k < AUX_N; k++) begin : g_aux
    assign aux_wr[k] = win_hit && (ofs == 4'(k));
  end

  AST_PRG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_hit && ofs == OFS_PRG) |=> $stable(prg_bank)); // R3
  AST_AUX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(aux_wr)); // R7
  AST_AUX_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (|aux_wr) |-> cpu_wr); // R7
  AST_XATTR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    xattr_wr |-> !(|aux_wr)); // R3
endmodule

// File: rtl/cmap_addr.sv
module cmap_addr
  import cmap_pkg::*;
#(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 4,
  localparam int CHR_SLOTS = 2 ** (13 - CHR_WIN_W),
  localparam int PRG_AW    = PRG_BANK_W + PRG_WIN_W,
  localparam int CHR_AW    = CHR_BANK_W + CHR_WIN_W
) (
  input  logic [15:0]                     cpu_addr,
  input  logic                            cpu_wr,
  input  logic [13:0]                     ppu_addr,
  input  logic [PRG_BANK_W-1:0]           prg_bank,
  input  logic [CHR_SLOTS*CHR_BANK_W-1:0] chr_bank,
  input  ctrl_t                           ctrl,
  output logic [PRG_AW-1:0]               prg_rom_addr,
  output logic                            prg_rom_ce,
  output logic [RAM_AW-1:0]               prg_ram_addr,
  output logic                            prg_ram_ce,
  output logic                            prg_ram_we,
  output logic [CHR_AW-1:0]               chr_addr,
  output logic                            chr_ce,
  output logic                            ciram_a10,
  output logic                            ciram_ce
);
  localparam int SLOT_W = $clog2(CHR_SLOTS);

  logic [PRG_BANK_W-1:0] bank_now;
  logic [SLOT_W-1:0]     slot;

  always_comb begin
    bank_now     = cpu_addr[14] ? {PRG_BANK_W{1'b1}} : prg_bank;
    prg_rom_ce   = cpu_addr[15];
    prg_rom_addr = {bank_now, cpu_addr[PRG_WIN_W-1:0]};
  end

  always_comb begin
    prg_ram_ce   = (cpu_addr[15:13] == 3'b011);
    prg_ram_addr = cpu_addr[RAM_AW-1:0];
    prg_ram_we   = prg_ram_ce && cpu_wr && ctrl.ram_wr_en;
  end

  always_comb begin
    slot     = ppu_addr[12:CHR_WIN_W];
    chr_ce   = !ppu_addr[13];
    chr_addr = {chr_bank[slot*CHR_BANK_W +: CHR_BANK_W], ppu_addr[CHR_WIN_W-1:0]};
  end

  always_comb begin
    ciram_ce = ppu_addr[13];
    unique case (ctrl.mirror)
      MIR_VERT:  ciram_a10 = ppu_addr[10];
      MIR_HORIZ: ciram_a10 = ppu_addr[11];
      MIR_ONE_A: ciram_a10 = 1'b0;
      MIR_ONE_B: ciram_a10 = 1'b1;
      default:   ciram_a10 = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmap_xattr.sv
module cmap_xattr
  import cmap_pkg::*;
#(
  localparam int IDX_W = NT_OFS_W + 1,
  localparam int DEPTH = 2 ** IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xattr_wr,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_pal,
  input  logic             ppu_rd,
  input  logic [13:0]      ppu_addr,
  input  logic             ciram_a10,
  input  logic             xattr_en,
  output logic             attr_ovr,
  output logic [7:0]       attr_data
);
  logic [1:0]       pal_mem [DEPTH];
  logic [1:0]       pal_q;
  logic             is_attr;
  logic             tile_fetch;
  logic [IDX_W-1:0] rd_idx;
  logic             unused_xattr;

  assign unused_xattr = ^ppu_addr[12:10];
  assign is_attr      = ppu_addr[13] && (ppu_addr[9:6] == 4'hF);
  assign tile_fetch   = ppu_rd && ppu_addr[13] && (ppu_addr[9:6] != 4'hF);
  assign rd_idx       = {ciram_a10, ppu_addr[NT_OFS_W-1:0]};

  always_ff @(posedge clk) begin
    if (xattr_wr) pal_mem[wr_idx] <= wr_pal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pal_q <= '0;
    else if (tile_fetch) pal_q <= pal_mem[rd_idx];
  end

  always_comb begin
    attr_ovr  = xattr_en && ppu_rd && is_attr;
    attr_data = attr_ovr ? {4{pal_q}} : 8'h00;
  end

  AST_PAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tile_fetch |=> $stable(pal_q)); // R9
  AST_ATTR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    attr_ovr |-> (attr_data[7:6] == attr_data[1:0] && attr_data[5:4] == attr_data[3:2]
                  && attr_data[3:2] == attr_data[1:0])); // R9
  AST_ATTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !xattr_en |-> (!attr_ovr && attr_data == 8'h00)); // R10
endmodule

// File: rtl/cart_map_core.sv
module cart_map_core
  import cmap_pkg::*;
#(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 4,
  parameter int AUX_N      = 10,
  localparam int CHR_SLOTS = 2 ** (13 - CHR_WIN_W),
  localparam int PRG_AW    = PRG_BANK_W + PRG_WIN_W,
  localparam int CHR_AW    = CHR_BANK_W + CHR_WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic [13:0]       ppu_addr,
  input  logic              ppu_rd,
  output logic [PRG_AW-1:0] prg_rom_addr,
  output logic              prg_rom_ce,
  output logic [RAM_AW-1:0] prg_ram_addr,
  output logic              prg_ram_ce,
  output logic              prg_ram_we,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              chr_ce,
  output logic              ciram_a10,
  output logic              ciram_ce,
  output logic              attr_ovr,
  output logic [7:0]        attr_data,
  output logic [AUX_N-1:0]  aux_wr
);
  logic [PRG_BANK_W-1:0]           prg_bank;
  logic [CHR_SLOTS*CHR_BANK_W-1:0] chr_bank;
  ctrl_t                           ctrl;
  logic                            xattr_wr;

  cmap_regs #(
    .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W), .AUX_N(AUX_N)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .prg_bank(prg_bank), .chr_bank(chr_bank),
    .ctrl(ctrl), .aux_wr(aux_wr), .xattr_wr(xattr_wr)
  );

  cmap_addr #(
    .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)
  ) u_addr (
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .ppu_addr(ppu_addr),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .ctrl(ctrl),
    .prg_rom_addr(prg_rom_addr), .prg_rom_ce(prg_rom_ce),
    .prg_ram_addr(prg_ram_addr), .prg_ram_ce(prg_ram_ce), .prg_ram_we(prg_ram_we),
    .chr_addr(chr_addr), .chr_ce(chr_ce), .ciram_a10(ciram_a10), .ciram_ce(ciram_ce)
  );

  cmap_xattr u_xattr (
    .clk(clk), .rst_n(rst_n), .xattr_wr(xattr_wr),
    .wr_idx(cpu_addr[NT_OFS_W:0]), .wr_pal(cpu_wdata[1:0]),
    .ppu_rd(ppu_rd), .ppu_addr(ppu_addr), .ciram_a10(ciram_a10),
    .xattr_en(ctrl.xattr_en), .attr_ovr(attr_ovr), .attr_data(attr_data)
  );

  AST_RAM_WE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    prg_ram_we |-> (ctrl.ram_wr_en && cpu_wr)); // R6
  AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b11) |-> (&prg_rom_addr[PRG_AW-1:PRG_WIN_W])); // R2
  AST_ONE_SCREEN_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mirror == MIR_ONE_B) |-> ciram_a10); // R5
endmodule

// File: tb/tb_cart_map_core.sv
`timescale 1ns/1ps
module tb_cart_map_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        ppu_rd = 1'b0;
  logic [17:0] prg_rom_addr;
  logic        prg_rom_ce;
  logic [12:0] prg_ram_addr;
  logic        prg_ram_ce;
  logic        prg_ram_we;
  logic [14:0] chr_addr;
  logic        chr_ce;
  logic        ciram_a10;
  logic        ciram_ce;
  logic        attr_ovr;
  logic [7:0]  attr_data;
  logic [9:0]  aux_wr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cart_map_core dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .ppu_rd(ppu_rd),
    .prg_rom_addr(prg_rom_addr), .prg_rom_ce(prg_rom_ce),
    .prg_ram_addr(prg_ram_addr), .prg_ram_ce(prg_ram_ce), .prg_ram_we(prg_ram_we),
    .chr_addr(chr_addr), .chr_ce(chr_ce), .ciram_a10(ciram_a10), .ciram_ce(ciram_ce),
    .attr_ovr(attr_ovr), .attr_data(attr_data), .aux_wr(aux_wr)
  );

  // {write address, write data, probe address, expected ROM address}
  localparam logic [57:0] VEC [0:7] = '{
    {16'h800B, 8'h03, 16'h8123, 18'h0C123},  // R1 direct entry
    {16'hBFFB, 8'h07, 16'hA000, 18'h1E000},  // R3 alias at top of window
    {16'hC00B, 8'h09, 16'h8000, 18'h1C000},  // R3 upper half ignored
    {16'h807B, 8'h25, 16'h9FFF, 18'h15FFF},  // R1 low 4 data bits only
    {16'h800A, 8'h00, 16'h8001, 18'h14001},  // R3 other entry ignored
    {16'h900B, 8'h0F, 16'h8000, 18'h3C000},  // R1 highest bank
    {16'h800B, 8'h00, 16'hC000, 18'h3C000},  // R2 fixed bank
    {16'h8FFB, 8'h0A, 16'hFFFF, 18'h3FFFF}   // R2 fixed bank top
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic tile_then_attr(input logic [13:0] tile, input logic [13:0] attr);
    @(negedge clk);
    ppu_addr = tile; ppu_rd = 1'b1;
    @(negedge clk);
    ppu_addr = attr;
    #1;
  endtask

  task automatic mirror_probe(input logic [1:0] mode, input logic exp_2400, input logic exp_2800);
    cpu_write(16'h800A, {6'b0, mode});
    ppu_addr = 14'h2400; #1;
    check("R5 a10 at 2400", {31'b0, ciram_a10}, {31'b0, exp_2400});
    ppu_addr = 14'h2800; #1;
    check("R5 a10 at 2800", {31'b0, ciram_a10}, {31'b0, exp_2800});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    cpu_addr = 16'h8000; ppu_addr = 14'h2400; #1;
    check("R11 prg bank zero", 32'(prg_rom_addr), 32'h0);
    check("R11 vertical a10", {31'b0, ciram_a10}, 32'h1);
    ppu_addr = 14'h1800; #1;
    check("R11 chr bank zero", 32'(chr_addr), 32'h0);
    ppu_addr = 14'h23C0; ppu_rd = 1'b1; #1;
    check("R11 override off", {23'b0, attr_ovr, attr_data}, 32'h0);
    ppu_rd = 1'b0;
    cpu_addr = 16'h6000; cpu_wr = 1'b1; #1;
    check("R11 ram write blocked", {31'b0, prg_ram_we}, 32'h0);
    @(negedge clk); cpu_wr = 1'b0;

    // R1 R2 R3 vector table
    for (int i = 0; i < 8; i++) begin
      cpu_write(VEC[i][57:42], VEC[i][41:34]);
      cpu_addr = VEC[i][33:18]; #1;
      check("R1/R2/R3 prg vector", 32'(prg_rom_addr), 32'(VEC[i][17:0]));
      check("R1 rom ce", {31'b0, prg_rom_ce}, 32'h1);
    end

    // R4 character banks
    cpu_write(16'h800C, 8'h01);
    cpu_write(16'h800D, 8'h02);
    cpu_write(16'h800E, 8'h03);
    cpu_write(16'h800F, 8'hF4);
    ppu_addr = 14'h0010; #1; check("R4 slot0", 32'(chr_addr), 32'h0810);
    ppu_addr = 14'h0810; #1; check("R4 slot1", 32'(chr_addr), 32'h1010);
    ppu_addr = 14'h1000; #1; check("R4 slot2", 32'(chr_addr), 32'h1800);
    ppu_addr = 14'h1FFF; #1; check("R4 slot3", 32'(chr_addr), 32'h27FF);
    check("R4 chr ce", {31'b0, chr_ce}, 32'h1);

    // R5 mirroring modes
    mirror_probe(2'd0, 1'b1, 1'b0);
    mirror_probe(2'd1, 1'b0, 1'b1);
    mirror_probe(2'd2, 1'b0, 1'b0);
    mirror_probe(2'd3, 1'b1, 1'b1);

    // R6 work RAM gate
    cpu_write(16'h800A, 8'h00);
    @(negedge clk);
    cpu_addr = 16'h7ABC; cpu_wr = 1'b1; #1;
    check("R6 ram ce", {31'b0, prg_ram_ce}, 32'h1);
    check("R6 ram addr", 32'(prg_ram_addr), 32'h1ABC);
    check("R6 we blocked", {31'b0, prg_ram_we}, 32'h0);
    @(negedge clk); cpu_wr = 1'b0;
    cpu_write(16'h800A, 8'h08);
    @(negedge clk);
    cpu_addr = 16'h6000; cpu_wr = 1'b1; #1;
    check("R6 we passes", {31'b0, prg_ram_we}, 32'h1);
    @(negedge clk); cpu_wr = 1'b0; #1;
    check("R6 we idle", {31'b0, prg_ram_we}, 32'h0);

    // R7 auxiliary strobes
    @(negedge clk); cpu_addr = 16'h8009; cpu_wr = 1'b1; #1;
    check("R7 entry 9", 32'(aux_wr), 32'h200);
    @(negedge clk); cpu_addr = 16'hA7F5; #1;
    check("R7 entry 5 alias", 32'(aux_wr), 32'h020);
    @(negedge clk); cpu_addr = 16'h800A; cpu_wdata = 8'h08; #1;
    check("R7 entry A none", 32'(aux_wr), 32'h0);
    @(negedge clk); cpu_addr = 16'hC009; cpu_wdata = 8'h00; #1;
    check("R7 upper half none", 32'(aux_wr), 32'h0);
    @(negedge clk); cpu_wr = 1'b0; #1;
    check("R7 idle", 32'(aux_wr), 32'h0);

    // R8 palette fill (feature disabled during the writes)
    cpu_write(16'hC523, 8'hFE);  // second table, value 2
    cpu_write(16'hF123, 8'h01);  // alias of first table $123, value 1

    // R10 feature off
    tile_then_attr(14'h2523, 14'h27C8);
    check("R10 override off", {23'b0, attr_ovr, attr_data}, 32'h0);
    ppu_rd = 1'b0;

    // R9 vertical: $2523 -> offset $523
    cpu_write(16'h800A, 8'h04);
    tile_then_attr(14'h2523, 14'h27C8);
    check("R9 vertical second table", {23'b0, attr_ovr, attr_data}, 32'h1AA);
    ppu_rd = 1'b0;
    tile_then_attr(14'h2123, 14'h23C8);
    check("R8 first table entry", {23'b0, attr_ovr, attr_data}, 32'h155);
    ppu_rd = 1'b0;

    // R9 horizontal: $2923 -> offset $523
    cpu_write(16'h800A, 8'h05);
    tile_then_attr(14'h2923, 14'h2BC8);
    check("R9 horizontal", {23'b0, attr_ovr, attr_data}, 32'h1AA);
    ppu_rd = 1'b0;

    // R9 single-screen A: $2923 -> offset $123
    cpu_write(16'h800A, 8'h06);
    tile_then_attr(14'h2923, 14'h2BC8);
    check("R9 single A", {23'b0, attr_ovr, attr_data}, 32'h155);
    ppu_rd = 1'b0;

    // R9 attribute read without strobe gives no override
    #1; check("R9 needs read strobe", {31'b0, attr_ovr}, 32'h0);

    // R10 disable again
    cpu_write(16'h800A, 8'h02);
    tile_then_attr(14'h2923, 14'h2BC8);
    check("R10 disabled again", {23'b0, attr_ovr, attr_data}, 32'h0);
    ppu_rd = 1'b0;

    // R11 reset clears registers again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cpu_addr = 16'hBFFF; ppu_addr = 14'h0800; #1;
    check("R11 prg after reset", 32'(prg_rom_addr), 32'h03FFF);
    check("R11 chr after reset", 32'(chr_addr), 32'h0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule